// File: doc/BRIEF.md
# Parallel YUV422 Capture Front End

This block sits behind an 8-bit parallel camera port that sends YUV422 samples with separate horizontal and vertical sync lines. It samples a wider raw pin bus, takes the video byte lane out of that bus through two masks, and detects the active edges of both syncs with a programmable polarity. It counts bytes from each line sync and lines from each frame sync, and keeps only the bytes inside a programmed window. It packs each group of four window bytes (two pixels) into one 32-bit word.

The component order of the incoming group is given by one 2-bit code and the order of the emitted word by another. Words come out with a one-cycle valid, a start-of-frame marker on the first word of a frame, an end-of-line marker on the last word of each line, and a single-cycle frame-done pulse. Capture is granted frame by frame. The enable and stop controls are read only at each frame sync edge.

Top module: `yuv_cap_front`

## Requirements
- R1: After reset, out_valid, out_sof, out_eol, frame_done and out_data are all zero.
- R2: The video byte is pin_data[9:2] ANDed with cfg_pin_en[9:2] and with cfg_data_en[9:2]. A clear bit in either mask forces that data bit to 0. Pins outside bits 9..2 have no effect on any output.
- R3: A sync is active while its pin equals its polarity bit (1 = active high, 0 = active low). Only the inactive-to-active transition counts as an edge.
- R4: The byte registered in the cycle of a line sync edge has index 0, and each later byte adds 1. Bytes with index from 2*cfg_h_start to 2*(cfg_h_start+cfg_h_len)-1 are in the window. All other bytes are dropped.
- R5: A frame sync edge sets the line counter so that the next line sync edge starts line 0. Lines cfg_v_start to cfg_v_start+cfg_v_len-1 are in the window.
- R6: Window bytes are grouped in fours, counted from the first window byte of each line. out_valid is high for exactly one cycle per completed group, two clock edges after the group's last byte is sampled at the pins.
- R7: Order codes name the component sequence of a group: 0 = U,Y0,V,Y1; 1 = V,Y0,U,Y1; 2 = Y0,U,Y1,V; 3 = Y0,V,Y1,U. cfg_in_order describes the arriving bytes, and cfg_out_order sets the emitted word, whose first component is in out_data[31:24] and whose last is in out_data[7:0].
- R8: out_sof marks the first word of the first window line. out_eol marks the word that holds window byte 2*(cfg_h_start+cfg_h_len)-1. Both are high only together with out_valid.
- R9: At each frame sync edge the block samples the controls. The following frame is captured only if ctl_enable=1 and ctl_stop=0. Control changes within a frame do not affect that frame.
- R10: frame_done pulses for one cycle, together with out_eol, on the last window line of a captured frame.
- R11: A line sync edge in the middle of a line restarts the byte index at 0 and advances the line counter, with no error. A partly assembled group is discarded and never joins bytes of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_data | input | 12 | Raw camera data pins |
| pin_hs | input | 1 | Line sync pin |
| pin_vs | input | 1 | Frame sync pin |
| cfg_pin_en | input | 12 | Per-pin input enable mask |
| cfg_data_en | input | 12 | Per-pin data mask toward the core |
| cfg_hs_pol | input | 1 | Line sync polarity, 1 = active high |
| cfg_vs_pol | input | 1 | Frame sync polarity, 1 = active high |
| cfg_h_start | input | 12 | First window pixel of a line |
| cfg_h_len | input | 12 | Window pixels per line, even |
| cfg_v_start | input | 12 | First window line |
| cfg_v_len | input | 12 | Window lines per frame |
| cfg_in_order | input | 2 | Component order of incoming groups |
| cfg_out_order | input | 2 | Component order of emitted words |
| ctl_enable | input | 1 | Capture enable, read at frame sync edges |
| ctl_stop | input | 1 | Stop after the current frame, read at frame sync edges |
| out_valid | output | 1 | Word valid strobe |
| out_data | output | 32 | Pixel-pair word |
| out_sof | output | 1 | First word of frame |
| out_eol | output | 1 | Last word of line |
| frame_done | output | 1 | Captured frame completed |

## Verification
The assertions check on every cycle that markers only appear with a valid word, that valid words are separated by idle cycles as group assembly requires, and that frame_done is a one-cycle pulse on an end-of-line word. Window placement, masking, polarity, byte reordering and the frame-by-frame grant of capture depend on the pin stream and on the configuration. Only the bench's reference model, fed by those scenarios, can show them. The same holds for the discarding of partial groups when a line sync arrives early.

// File: rtl/yuv_cap_front.sv
`timescale 1ns/1ps
module yuv_cap_front #(
  parameter int PIN_W    = 12,
  parameter int LANE_LSB = 2,
  parameter int PIX_W    = 8,
  parameter int CNT_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_W-1:0]   pin_data,
  input  logic               pin_hs,
  input  logic               pin_vs,
  input  logic [PIN_W-1:0]   cfg_pin_en,
  input  logic [PIN_W-1:0]   cfg_data_en,
  input  logic               cfg_hs_pol,
  input  logic               cfg_vs_pol,
  input  logic [CNT_W-1:0]   cfg_h_start,
  input  logic [CNT_W-1:0]   cfg_h_len,
  input  logic [CNT_W-1:0]   cfg_v_start,
  input  logic [CNT_W-1:0]   cfg_v_len,
  input  logic [1:0]         cfg_in_order,
  input  logic [1:0]         cfg_out_order,
  input  logic               ctl_enable,
  input  logic               ctl_stop,
  output logic               out_valid,
  output logic [4*PIX_W-1:0] out_data,
  output logic               out_sof,
  output logic               out_eol,
  output logic               frame_done
);
  localparam int LANE_MSB = LANE_LSB + PIX_W - 1;
  localparam int IDX_W    = CNT_W + 1;
  localparam int END_W    = CNT_W + 2;
  localparam logic [PIN_W-1:0] LANE_MASK = PIN_W'(((1 << PIX_W) - 1) << LANE_LSB);

  function automatic logic [4*PIX_W-1:0] to_canon(input logic [1:0] ord,
      input logic [PIX_W-1:0] b0, input logic [PIX_W-1:0] b1,
      input logic [PIX_W-1:0] b2, input logic [PIX_W-1:0] b3);
    case (ord)
      2'd0:    return {b0, b1, b2, b3};
      2'd1:    return {b2, b1, b0, b3};
      2'd2:    return {b1, b0, b3, b2};
      default: return {b3, b0, b1, b2};
    endcase
  endfunction

  function automatic logic [4*PIX_W-1:0] from_canon(input logic [1:0] ord,
      input logic [4*PIX_W-1:0] c);
    logic [PIX_W-1:0] u, y0, v, y1;
    {u, y0, v, y1} = c;
    case (ord)
      2'd0:    return {u, y0, v, y1};
      2'd1:    return {v, y0, u, y1};
      2'd2:    return {y0, u, y1, v};
      default: return {y0, v, y1, u};
    endcase
  endfunction

  wire [PIN_W-1:0] pin_sel = pin_data & cfg_pin_en & cfg_data_en;
  wire unused_pins = ^(pin_sel & ~LANE_MASK);

  logic [PIX_W-1:0] px_q;
  logic             hs_q, vs_q, hs_prev, vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q    <= '0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
    end else begin
      px_q    <= pin_sel[LANE_MSB:LANE_LSB];
      hs_q    <= (pin_hs == cfg_hs_pol);
      vs_q    <= (pin_vs == cfg_vs_pol);
      hs_prev <= hs_q;
      vs_prev <= vs_q;
    end
  end

  wire hs_edge = hs_q & ~hs_prev;
  wire vs_edge = vs_q & ~vs_prev;

  logic [IDX_W-1:0] byte_cnt;
  logic [CNT_W-1:0] line_cnt;
  logic             grab;

  wire [IDX_W-1:0] byte_idx = hs_edge ? '0 : byte_cnt;
  wire [CNT_W-1:0] line_cur = (vs_edge ? '1 : line_cnt) + CNT_W'(hs_edge);
  wire             grab_cur = vs_edge ? (ctl_enable & ~ctl_stop) : grab;

  wire [END_W-1:0] h_first = {1'b0, cfg_h_start, 1'b0};
  wire [END_W-1:0] h_end   = ({2'b0, cfg_h_start} + {2'b0, cfg_h_len}) << 1;
  wire [END_W-1:0] idx_x   = {1'b0, byte_idx};
  wire [END_W-1:0] h_rel   = idx_x - h_first;
  wire [CNT_W:0]   v_end   = {1'b0, cfg_v_start} + {1'b0, cfg_v_len};
  wire [CNT_W:0]   line_x  = {1'b0, line_cur};

  wire       in_h   = (idx_x >= h_first) && (idx_x < h_end);
  wire       in_v   = (line_cur >= cfg_v_start) && (line_x < v_end);
  wire       take   = grab_cur && in_h && in_v;
  wire [1:0] slot   = h_rel[1:0];
  wire       emit   = take && (slot == 2'd3);
  wire       last_h = (idx_x == h_end - END_W'(1));
  wire       last_v = (line_x == v_end - (CNT_W + 1)'(1));
  wire       first_grp = (h_rel[END_W-1:2] == '0) && (line_cur == cfg_v_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '1;
      line_cnt <= '1;
      grab     <= 1'b0;
    end else begin
      byte_cnt <= (&byte_idx) ? byte_idx : byte_idx + IDX_W'(1);
      line_cnt <= line_cur;
      grab     <= grab_cur;
    end
  end

  logic [PIX_W-1:0] hold0, hold1, hold2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold0 <= '0;
      hold1 <= '0;
      hold2 <= '0;
    end else if (take) begin
      case (slot)
        2'd0:    hold0 <= px_q;
        2'd1:    hold1 <= px_q;
        2'd2:    hold2 <= px_q;
        default: ;
      endcase
    end
  end

  wire [4*PIX_W-1:0] canon = to_canon(cfg_in_order, hold0, hold1, hold2, px_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eol    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      out_valid  <= emit;
      out_sof    <= emit && first_grp;
      out_eol    <= emit && last_h;
      frame_done <= emit && last_h && last_v;
      if (emit) out_data <= from_canon(cfg_out_order, canon);
    end
  end
endmodule

// File: rtl/yuv_cap_front_chk.sv
`timescale 1ns/1ps
module yuv_cap_front_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_sof,
  input logic out_eol,
  input logic frame_done
);
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R8
  AST_EOL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid); // R8
  AST_GROUP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_DONE_ON_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (out_eol && out_valid)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R10
endmodule

bind yuv_cap_front yuv_cap_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .out_eol(out_eol), .frame_done(frame_done)
);

// File: tb/yuv_cap_front_test.sv
`timescale 1ns/1ps
module yuv_cap_front_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [11:0] pin_data, cfg_pin_en, cfg_data_en;
  logic        pin_hs, pin_vs, cfg_hs_pol, cfg_vs_pol;
  logic [11:0] cfg_h_start, cfg_h_len, cfg_v_start, cfg_v_len;
  logic [1:0]  cfg_in_order, cfg_out_order;
  logic        ctl_enable, ctl_stop;
  logic        out_valid, out_sof, out_eol, frame_done;
  logic [31:0] out_data;

  yuv_cap_front uut (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_hs(pin_hs), .pin_vs(pin_vs),
    .cfg_pin_en(cfg_pin_en), .cfg_data_en(cfg_data_en),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_h_start(cfg_h_start), .cfg_h_len(cfg_h_len),
    .cfg_v_start(cfg_v_start), .cfg_v_len(cfg_v_len),
    .cfg_in_order(cfg_in_order), .cfg_out_order(cfg_out_order),
    .ctl_enable(ctl_enable), .ctl_stop(ctl_stop),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .frame_done(frame_done)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  int    n_grp, n_sof, n_eol, n_done;
  bit    running = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // component carried at a position for an order code: 0=U 1=Y0 2=V 3=Y1
  function automatic int comp_at(input int ord, input int pos);
    int t0[4] = '{0, 1, 2, 3};
    int t1[4] = '{2, 1, 0, 3};
    int t2[4] = '{1, 0, 3, 2};
    int t3[4] = '{1, 2, 3, 0};
    case (ord)
      0: return t0[pos];
      1: return t1[pos];
      2: return t2[pos];
      default: return t3[pos];
    endcase
  endfunction

  // behavioural reference
  logic [7:0]  q[$];
  logic [7:0]  s_px;
  bit          s_hs, s_vs, m_hsp, m_vsp, m_cap;
  int          m_bidx, m_line;
  logic        e_valid, e_sof, e_eol, e_done;
  logic [31:0] e_data;

  always @(posedge clk) begin : model
    bit hse, vse, act;
    int idx, rel, hs0, hl, vs0, vl;
    logic [7:0] c[4];
    if (!rst_n) begin
      s_px = 0; s_hs = 0; s_vs = 0; m_hsp = 0; m_vsp = 0; m_cap = 0;
      m_bidx = 1 << 20; m_line = -1; q.delete();
      e_valid = 0; e_sof = 0; e_eol = 0; e_done = 0; e_data = 0;
    end else begin
      hs0 = int'(cfg_h_start); hl = int'(cfg_h_len);
      vs0 = int'(cfg_v_start); vl = int'(cfg_v_len);
      hse = s_hs && !m_hsp; vse = s_vs && !m_vsp;
      m_hsp = s_hs; m_vsp = s_vs;
      e_valid = 0; e_sof = 0; e_eol = 0; e_done = 0;
      if (vse) begin m_line = -1; m_cap = ctl_enable && !ctl_stop; end
      if (hse) begin m_line++; m_bidx = 0; end
      idx = m_bidx; rel = idx - 2 * hs0;
      act = m_cap && idx >= 2 * hs0 && idx < 2 * (hs0 + hl) && m_line >= vs0 && m_line < vs0 + vl;
      if (act) begin
        if (rel % 4 == 0) q.delete();
        q.push_back(s_px);
        if (rel % 4 == 3 && q.size() == 4) begin
          for (int p = 0; p < 4; p++) c[comp_at(int'(cfg_in_order), p)] = q[p];
          for (int p = 0; p < 4; p++) e_data[31-8*p -: 8] = c[comp_at(int'(cfg_out_order), p)];
          e_valid = 1;
          e_sof = (m_line == vs0) && (rel == 3);
          e_eol = (idx == 2 * (hs0 + hl) - 1);
          e_done = e_eol && (m_line == vs0 + vl - 1);
        end
      end
      m_bidx++;
      s_px = pin_data[9:2] & cfg_pin_en[9:2] & cfg_data_en[9:2];
      s_hs = (pin_hs === cfg_hs_pol);
      s_vs = (pin_vs === cfg_vs_pol);
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      check(out_valid === e_valid, cur_req, "out_valid", 32'(out_valid), 32'(e_valid));
      if (e_valid) check(out_data === e_data, cur_req, "out_data", out_data, e_data);
      check(out_sof === e_sof, "R8", "out_sof", 32'(out_sof), 32'(e_sof));
      check(out_eol === e_eol, "R8", "out_eol", 32'(out_eol), 32'(e_eol));
      check(frame_done === e_done, "R10", "frame_done", 32'(frame_done), 32'(e_done));
      if (out_valid && cur_req == "R2")
        check((out_data & 32'h4848_4848) == 0, "R2", "masked bits", out_data, out_data & ~32'h4848_4848);
      if (out_valid) n_grp++;
      if (out_sof) n_sof++;
      if (out_eol) n_eol++;
      if (frame_done) n_done++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic clr();
    n_grp = 0; n_sof = 0; n_eol = 0; n_done = 0;
  endtask

  task automatic frame(input int nlines = 5, input int nbytes = 20, input int rst_line = -1,
                       input int rst_b = 0, input int stop_line = -1, input int drop_line = -1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin_vs = cfg_vs_pol; pin_hs = ~cfg_hs_pol; pin_data = 12'($urandom);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); pin_vs = ~cfg_vs_pol; pin_data = 12'($urandom);
    end
    for (int l = 0; l < nlines; l++) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        if (l == stop_line) ctl_stop = 1'b1;
        if (l == drop_line) ctl_enable = 1'b0;
        pin_hs = cfg_hs_pol; pin_data = 12'($urandom);
      end
      for (int b = 0; b < nbytes; b++) begin
        @(negedge clk);
        pin_hs = (l == rst_line && b == rst_b) ? cfg_hs_pol : ~cfg_hs_pol;
        pin_data = 12'($urandom);
      end
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pin_hs = ~cfg_hs_pol; pin_data = 12'($urandom);
    end
  endtask

  initial begin
    rst_n = 0; pin_data = 0; cfg_hs_pol = 0; cfg_vs_pol = 0; pin_hs = 1; pin_vs = 1;
    cfg_pin_en = 12'hFFF; cfg_data_en = 12'hFFF;
    cfg_h_start = 1; cfg_h_len = 8; cfg_v_start = 1; cfg_v_len = 3;
    cfg_in_order = 0; cfg_out_order = 0; ctl_enable = 0; ctl_stop = 0;
    repeat (5) @(negedge clk);
    check({out_valid, out_sof, out_eol, frame_done} == 0 && out_data == 0, "R1",
          "reset outputs", {out_data[27:0], out_valid, out_sof, out_eol, frame_done}, 0);
    rst_n = 1;
    @(negedge clk);
    check({out_valid, out_sof, out_eol, frame_done} == 0, "R1", "post-reset flags",
          32'({out_valid, out_sof, out_eol, frame_done}), 0);
    running = 1;

    cur_req = "R9"; clr(); frame();
    check(n_grp == 0, "R9", "words with enable low", n_grp, 0);

    cur_req = "R4"; ctl_enable = 1; clr(); frame(); frame();
    check(n_grp == 24, "R6", "word count", n_grp, 24);
    check(n_sof == 2, "R8", "sof count", n_sof, 2);
    check(n_eol == 6, "R8", "eol count", n_eol, 6);
    check(n_done == 2, "R10", "done count", n_done, 2);

    cur_req = "R7"; clr();
    for (int i = 0; i < 4; i++) begin
      cfg_in_order = 2'(i); cfg_out_order = 2'((i + 1) % 4); frame();
    end
    cfg_in_order = 2; cfg_out_order = 2; frame();
    check(n_done == 5, "R7", "frames in order sweep", n_done, 5);

    cur_req = "R3"; clr();
    @(negedge clk); cfg_hs_pol = 1; cfg_vs_pol = 1; pin_hs = 0; pin_vs = 0;
    frame();
    check(n_grp == 12, "R3", "words with high polarity", n_grp, 12);

    cur_req = "R2"; clr(); cfg_in_order = 0; cfg_out_order = 1;
    cfg_pin_en = 12'hFDF; cfg_data_en = 12'hEFF; frame();
    check(n_grp == 12, "R2", "words with masks", n_grp, 12);
    cfg_pin_en = 12'hFFF; cfg_data_en = 12'hFFF;

    cur_req = "R5"; clr(); cfg_h_start = 0; cfg_h_len = 4; cfg_v_start = 0; cfg_v_len = 2;
    frame();
    check(n_grp == 4, "R5", "words in small window", n_grp, 4);
    check(n_done == 1, "R5", "done in small window", n_done, 1);

    cur_req = "R11"; clr(); cfg_h_start = 1; cfg_h_len = 8; cfg_v_start = 1; cfg_v_len = 3;
    frame(5, 20, 1, 5);
    check(n_grp == 8, "R11", "words with early line sync", n_grp, 8);
    check(n_eol == 1, "R11", "eol with early line sync", n_eol, 1);
    check(n_done == 1, "R11", "done with early line sync", n_done, 1);

    cur_req = "R9"; clr();
    frame(5, 20, -1, 0, 2);
    frame();
    ctl_stop = 0;
    frame(5, 20, -1, 0, -1, 2);
    frame();
    check(n_done == 2, "R9", "frames granted by controls", n_done, 2);
    check(n_grp == 24, "R9", "words granted by controls", n_grp, 24);

    running = 0;
    finish_run();
  end
endmodule